// File: doc/BRIEF.md
# Interrupt priority level arbiter

This block decides whether a pending interrupt should be taken. It merges a software request register with a vector of external interrupt lines. From them it picks one winning priority level and builds a summary bit vector of everything pending. The winning level is compared with a programmable current priority level. Only a strictly higher, nonzero level causes the interrupt to be taken. A taken interrupt latches the summary and the winning level, and emits a one-cycle take pulse.

Evaluation is on demand. A controller pulses the check request, for example after a return from an exception handler. The block clears its internal pending-check flag as the evaluation starts. Asynchronous-trap requests are not supported, so any nonzero request on that input at evaluation time raises an error pulse.

Top module: `ipl_arbiter`

## Requirements
- R1: Reset (synchronous, active high) clears the take pulse, the error pulse, the latched summary, the latched level, the software request register and the current level to zero.
- R2: A write to the software request register keeps only bits 4 through 18 (mask 0x0007FFF0) and discards all other bits. The stored value appears on `sw_req_q` the cycle after the write.
- R3: A write to the current level keeps only the low 5 bits of the 8-bit write data. The result appears on `cur_lvl` the cycle after the write.
- R4: Software request bit i, for i in 4..18, stands for level i-3. Among software bits, the highest set bit gives the level.
- R5: External line i, for i in 20..30, stands for level i, and the highest set line gives the level. Lines 0..19 and 31 are ignored: they add no level and no summary bit.
- R6: Any pending in-range external line wins over every software request.
- R7: The summary is the OR of all set software request bits and all set in-range external lines, each kept at its own bit position.
- R8: An interrupt is taken only when the winning level is nonzero and strictly greater than `cur_lvl`. When no interrupt is taken, `isr_q` and `intid_q` keep their previous values.
- R9: A check request sampled at clock edge N is evaluated at edge N+1. After edge N+1, `take_irq` is high for exactly one cycle and `isr_q`/`intid_q` hold the new values. A check request seen while an evaluation is pending is dropped, so a held request evaluates on every second cycle.
- R10: If `async_req` is nonzero at evaluation, `async_err` pulses high for one cycle alongside the result. The take decision is unaffected by the error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | 32 | Software request write data |
| lvl_wr_en | input | 1 | Write strobe for the current level |
| lvl_wr_data | input | 8 | Current level write data (low 5 bits kept) |
| ext_irq | input | 32 | External interrupt lines, bit index is the level |
| async_req | input | 4 | Asynchronous-trap request bits (unsupported) |
| check_req | input | 1 | Request an evaluation |
| take_irq | output | 1 | One-cycle pulse: interrupt taken |
| async_err | output | 1 | One-cycle pulse: asynchronous-trap request seen |
| isr_q | output | 32 | Latched summary of pending bits |
| intid_q | output | 5 | Latched winning level |
| sw_req_q | output | 32 | Software request register |
| cur_lvl | output | 5 | Current priority level |

## Verification
The hardest case to reach from the ports is the boundary where the winning level equals the current level. Reaching it needs a prior taken interrupt, so the bench can see that the latched values are held rather than reloaded. The stimulus table therefore orders its entries deliberately. A level-15 software request is first taken above level 14. It is then retried with the current level set to 15 and must not be taken. Later entries show that out-of-range external lines leave the held values untouched, and that a held check request produces alternating evaluations.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

    localparam int SUM_W   = 32;
    localparam int WR_W    = 8;
    localparam int ASYNC_W = 4;
    localparam int SW_LO   = 4;
    localparam int SW_HI   = 18;
    localparam int EXT_LO  = 20;
    localparam int EXT_HI  = 30;
    localparam int SW_BASE = 1;

    // Bits lo..hi set, all others clear.
    function automatic logic [SUM_W-1:0] range_mask(input int lo, input int hi);
        logic [SUM_W-1:0] m;
        m = '0;
        for (int i = 0; i < SUM_W; i++) begin
            if (i >= lo && i <= hi) m[i] = 1'b1;
        end
        return m;
    endfunction

    typedef struct packed {
        logic             take;
        logic             err;
        logic [4:0]       lvl;
        logic [SUM_W-1:0] sum;
    } verdict_t;

endpackage

// File: rtl/ipl_range_enc.sv
module ipl_range_enc #(
    parameter int SUM_W = 32,
    parameter int LVL_W = 5,
    parameter int LO    = 4,
    parameter int HI    = 18,
    parameter int BASE  = 1
) (
    input  logic [SUM_W-1:0] req,
    output logic             hit,
    output logic [LVL_W-1:0] lvl,
    output logic [SUM_W-1:0] sum
);

    localparam logic [SUM_W-1:0] KEEP = ipl_pkg::range_mask(LO, HI);

    logic unused_req;
    assign unused_req = ^(req & ~KEEP);

    always_comb begin
        hit = 1'b0;
        lvl = '0;
        sum = '0;
        for (int i = LO; i <= HI; i++) begin
            if (req[i]) begin
                hit    = 1'b1;
                lvl    = LVL_W'(i - LO + BASE);
                sum[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ipl_ctrl_regs.sv
module ipl_ctrl_regs #(
    parameter int SUM_W = 32,
    parameter int LVL_W = 5,
    parameter int SW_LO = 4,
    parameter int SW_HI = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_wr_en,
    input  logic [SUM_W-1:0] sw_wr_data,
    input  logic             lvl_wr_en,
    input  logic [LVL_W-1:0] lvl_wr_lo,
    input  logic             check_req,
    output logic [SUM_W-1:0] sw_req_q,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             eval_now
);

    localparam logic [SUM_W-1:0] SW_KEEP = ipl_pkg::range_mask(SW_LO, SW_HI);

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_req_q <= '0;
            cur_lvl  <= '0;
            eval_now <= 1'b0;
        end else begin
            if (sw_wr_en)  sw_req_q <= sw_wr_data & SW_KEEP;
            if (lvl_wr_en) cur_lvl  <= lvl_wr_lo;
            // flag drops as the evaluation starts; requests during it are dropped
            eval_now <= eval_now ? 1'b0 : check_req;
        end
    end

endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
    parameter int SUM_W   = ipl_pkg::SUM_W,
    parameter int WR_W    = ipl_pkg::WR_W,
    parameter int ASYNC_W = ipl_pkg::ASYNC_W,
    parameter int SW_LO   = ipl_pkg::SW_LO,
    parameter int SW_HI   = ipl_pkg::SW_HI,
    parameter int EXT_LO  = ipl_pkg::EXT_LO,
    parameter int EXT_HI  = ipl_pkg::EXT_HI,
    localparam int LVL_W  = $clog2(SUM_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_wr_en,
    input  logic [SUM_W-1:0]   sw_wr_data,
    input  logic               lvl_wr_en,
    input  logic [WR_W-1:0]    lvl_wr_data,
    input  logic [SUM_W-1:0]   ext_irq,
    input  logic [ASYNC_W-1:0] async_req,
    input  logic               check_req,
    output logic               take_irq,
    output logic               async_err,
    output logic [SUM_W-1:0]   isr_q,
    output logic [LVL_W-1:0]   intid_q,
    output logic [SUM_W-1:0]   sw_req_q,
    output logic [LVL_W-1:0]   cur_lvl
);

    logic             eval_now;
    logic             sw_hit, ext_hit;
    logic [LVL_W-1:0] sw_lvl, ext_lvl, win_lvl;
    logic [SUM_W-1:0] sw_sum, ext_sum, all_sum;
    logic             lvl_unused;

    assign lvl_unused = ^lvl_wr_data[WR_W-1:LVL_W];

    ipl_ctrl_regs #(.SUM_W(SUM_W), .LVL_W(LVL_W), .SW_LO(SW_LO), .SW_HI(SW_HI)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .sw_wr_en  (sw_wr_en),
        .sw_wr_data(sw_wr_data),
        .lvl_wr_en (lvl_wr_en),
        .lvl_wr_lo (lvl_wr_data[LVL_W-1:0]),
        .check_req (check_req),
        .sw_req_q  (sw_req_q),
        .cur_lvl   (cur_lvl),
        .eval_now  (eval_now)
    );

    ipl_range_enc #(.SUM_W(SUM_W), .LVL_W(LVL_W), .LO(SW_LO), .HI(SW_HI),
                    .BASE(ipl_pkg::SW_BASE)) sw_enc_i (
        .req(sw_req_q), .hit(sw_hit), .lvl(sw_lvl), .sum(sw_sum)
    );

    ipl_range_enc #(.SUM_W(SUM_W), .LVL_W(LVL_W), .LO(EXT_LO), .HI(EXT_HI),
                    .BASE(EXT_LO)) ext_enc_i (
        .req(ext_irq), .hit(ext_hit), .lvl(ext_lvl), .sum(ext_sum)
    );

    ipl_pkg::verdict_t verdict;

    always_comb begin
        win_lvl      = ext_hit ? ext_lvl : (sw_hit ? sw_lvl : '0);
        all_sum      = sw_sum | ext_sum;
        verdict.take = eval_now && (win_lvl != '0) && (win_lvl > cur_lvl);
        verdict.err  = eval_now && (async_req != '0);
        verdict.lvl  = win_lvl;
        verdict.sum  = all_sum;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            take_irq  <= 1'b0;
            async_err <= 1'b0;
            isr_q     <= '0;
            intid_q   <= '0;
        end else begin
            take_irq  <= verdict.take;
            async_err <= verdict.err;
            if (verdict.take) begin
                isr_q   <= verdict.sum;
                intid_q <= verdict.lvl;
            end
        end
    end

endmodule

// File: rtl/ipl_arbiter_chk.sv
module ipl_arbiter_chk #(
    parameter int SUM_W   = 32,
    parameter int LVL_W   = 5,
    parameter int ASYNC_W = 4,
    parameter int SW_LO   = 4,
    parameter int SW_HI   = 18
) (
    input logic               clk,
    input logic               rst,
    input logic               sw_wr_en,
    input logic [SUM_W-1:0]   sw_wr_data,
    input logic               lvl_wr_en,
    input logic [LVL_W-1:0]   lvl_lo,
    input logic [ASYNC_W-1:0] async_req,
    input logic               take_irq,
    input logic               async_err,
    input logic [SUM_W-1:0]   isr_q,
    input logic [LVL_W-1:0]   intid_q,
    input logic [SUM_W-1:0]   sw_req_q,
    input logic [LVL_W-1:0]   cur_lvl
);

    localparam logic [SUM_W-1:0] CHK_MASK =
        ((SUM_W'(1) << (SW_HI + 1)) - SUM_W'(1)) ^ ((SUM_W'(1) << SW_LO) - SUM_W'(1));

    a_r2_sw_mask: assert property (@(posedge clk) disable iff (rst)
        $past(sw_wr_en) |-> sw_req_q == ($past(sw_wr_data) & CHK_MASK));

    a_r3_lvl_low5: assert property (@(posedge clk) disable iff (rst)
        $past(lvl_wr_en) |-> cur_lvl == $past(lvl_lo));

    a_r8_strict: assert property (@(posedge clk) disable iff (rst)
        take_irq |-> (intid_q != '0) && (intid_q > $past(cur_lvl)));

    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !take_irq |-> $stable(intid_q) && $stable(isr_q));

    a_r9_pulse: assert property (@(posedge clk) disable iff (rst)
        take_irq |=> !take_irq);

    a_r10_err: assert property (@(posedge clk) disable iff (rst)
        async_err |-> $past(async_req) != '0);

endmodule

bind ipl_arbiter ipl_arbiter_chk #(
    .SUM_W(SUM_W), .LVL_W(LVL_W), .ASYNC_W(ASYNC_W), .SW_LO(SW_LO), .SW_HI(SW_HI)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sw_wr_en  (sw_wr_en),
    .sw_wr_data(sw_wr_data),
    .lvl_wr_en (lvl_wr_en),
    .lvl_lo    (lvl_wr_data[LVL_W-1:0]),
    .async_req (async_req),
    .take_irq  (take_irq),
    .async_err (async_err),
    .isr_q     (isr_q),
    .intid_q   (intid_q),
    .sw_req_q  (sw_req_q),
    .cur_lvl   (cur_lvl)
);

// File: tb/ipl_arbiter_tb.sv
`timescale 1ns/1ps
module ipl_arbiter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        sw_wr_en, lvl_wr_en, check_req;
    logic [31:0] sw_wr_data, ext_irq;
    logic [7:0]  lvl_wr_data;
    logic [3:0]  async_req;
    logic        take_irq, async_err;
    logic [31:0] isr_q, sw_req_q;
    logic [4:0]  intid_q, cur_lvl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ipl_arbiter dut_i (
        .clk(clk), .rst(rst), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
        .lvl_wr_en(lvl_wr_en), .lvl_wr_data(lvl_wr_data), .ext_irq(ext_irq),
        .async_req(async_req), .check_req(check_req), .take_irq(take_irq),
        .async_err(async_err), .isr_q(isr_q), .intid_q(intid_q),
        .sw_req_q(sw_req_q), .cur_lvl(cur_lvl)
    );

    localparam int NV = 9;
    // sw write data, external lines, level write data, expected take/level/summary
    localparam logic [31:0] V_SW  [NV] = '{32'h0000_0010, 32'h0004_0000, 32'h0004_0000,
        32'h0000_0110, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_1000, 32'h0000_1000};
    localparam logic [31:0] V_EXT [NV] = '{32'h0, 32'h0, 32'h0, 32'h0010_0000,
        32'h4010_0000, 32'h800F_000F, 32'h8000_0001, 32'h0, 32'h0};
    localparam logic [7:0]  V_LVL [NV] = '{8'h00, 8'h2E, 8'hEF, 8'h05, 8'h1D, 8'h00, 8'hE0,
        8'h1F, 8'h08};
    localparam logic        V_TK  [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [4:0]  V_ID  [NV] = '{5'd1, 5'd15, 5'd15, 5'd20, 5'd30, 5'd30, 5'd15,
        5'd15, 5'd9};
    localparam logic [31:0] V_SUM [NV] = '{32'h0000_0010, 32'h0004_0000, 32'h0004_0000,
        32'h0010_0110, 32'h4010_0000, 32'h4010_0000, 32'h0007_FFF0, 32'h0007_FFF0, 32'h0000_1000};
    localparam string       V_TAG [NV] = '{"R4", "R3", "R8", "R6", "R5", "R5", "R7", "R8", "R4"};

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic setup(input logic [31:0] sw, input logic [7:0] lv, input logic [31:0] ext);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_data = sw; lvl_wr_en = 1'b1; lvl_wr_data = lv; ext_irq = ext;
        @(negedge clk);
        sw_wr_en = 1'b0; lvl_wr_en = 1'b0;
    endtask

    task automatic run_eval();
        check_req = 1'b1;
        @(negedge clk);
        check_req = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int takes;
        logic prev;
        rst = 1'b1; sw_wr_en = 0; lvl_wr_en = 0; check_req = 0;
        sw_wr_data = '0; lvl_wr_data = '0; ext_irq = '0; async_req = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1", "take", 32'(take_irq), 0);
        chk("R1", "err", 32'(async_err), 0);
        chk("R1", "isr", isr_q, 0);
        chk("R1", "intid", 32'(intid_q), 0);
        chk("R1", "sw", sw_req_q, 0);
        chk("R1", "cur", 32'(cur_lvl), 0);

        // R2 software mask
        setup(32'hFFFF_FFFF, 8'h00, 32'h0);
        chk("R2", "sw all ones", sw_req_q, 32'h0007_FFF0);
        setup(32'hFFF8_000F, 8'h00, 32'h0);
        chk("R2", "sw outside bits", sw_req_q, 32'h0);
        // R3 level write
        setup(32'h0, 8'hE5, 32'h0);
        chk("R3", "cur low5", 32'(cur_lvl), 32'd5);

        // table walk
        for (int k = 0; k < NV; k++) begin
            setup(V_SW[k], V_LVL[k], V_EXT[k]);
            run_eval();
            chk(V_TAG[k], $sformatf("vec%0d take", k), 32'(take_irq), 32'(V_TK[k]));
            chk(V_TAG[k], $sformatf("vec%0d intid", k), 32'(intid_q), 32'(V_ID[k]));
            chk(V_TAG[k], $sformatf("vec%0d isr", k), isr_q, V_SUM[k]);
        end

        // R9 timing of a single request
        setup(32'h0004_0000, 8'h00, 32'h0);
        check_req = 1'b1;
        @(negedge clk);
        check_req = 1'b0;
        chk("R9", "take after first edge", 32'(take_irq), 0);
        @(negedge clk);
        chk("R9", "take after second edge", 32'(take_irq), 1);
        @(negedge clk);
        chk("R9", "take one cycle", 32'(take_irq), 0);

        // R9 held request evaluates every second cycle
        takes = 0; prev = 1'b0;
        check_req = 1'b1;
        for (int c = 0; c < 7; c++) begin
            @(negedge clk);
            if (c == 5) check_req = 1'b0;
            if (take_irq) takes++;
            if (take_irq && prev) chk("R9", "consecutive take", 1, 0);
            prev = take_irq;
        end
        chk("R9", "held request take count", 32'(takes), 3);

        // R10 async error with and without take
        async_req = 4'h2;
        run_eval();
        chk("R10", "err with take", 32'(async_err), 1);
        chk("R10", "take with err", 32'(take_irq), 1);
        setup(32'h0004_0000, 8'h1F, 32'h0);
        run_eval();
        chk("R10", "err without take", 32'(async_err), 1);
        chk("R10", "no take", 32'(take_irq), 0);
        async_req = 4'h0;
        run_eval();
        chk("R10", "no err", 32'(async_err), 0);

        // R1 reset mid-run
        setup(32'h0, 8'h00, 32'h4000_0000);
        run_eval();
        chk("R5", "line 30 taken", 32'(intid_q), 32'd30);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1", "intid after reset", 32'(intid_q), 0);
        chk("R1", "isr after reset", isr_q, 0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule